// File: doc/BRIEF.md
# Fractional PLL Power Sequencer

This block turns a fractional-multiplier clock synthesiser on and off by issuing a fixed, ordered list of masked read-modify-write updates to two control registers. It masters a simple register bus. The first control register holds an active-low reset bit, an enable bit and the integer multiplier field. The second control register holds the fractional multiplier word. Each update reads the register, keeps every bit outside the step's mask, replaces the bits under the mask, and writes the result back to the same address.

Requests arrive on a valid/ready handshake. A request is accepted in a cycle where `req_valid` and `req_ready` are both high. `req_ready` is high only while no sequence is running, so the requester is back-pressured for the whole length of a sequence. The integer and fractional multipliers presented with the request are captured when it is accepted. The bus side is also valid/ready: `bus_req` is the valid and `bus_ack` is the ready. An access completes in the cycle where both are high. Until then the access stays pending with address, direction and write data unchanged. Read data is taken from `bus_rdata` in the completing cycle of a read.

Top module: `fpll_seq`

## Requirements
- R1: After reset, and whenever no sequence is running, `req_ready` is 1, `bus_req` is 0 and `done` is 0.
- R2: An accepted request with `req_on`=1 (power up) performs four updates in this order. First, register 0 gets reset bit 0 (`RSTN_BIT`) = 0. Second, register 0 gets reset bit 0 = 1. Third, register 1 gets fractional bits [21:0] = the captured fractional word. Fourth, register 0 gets, in one update, enable bit 1 (`EN_BIT`) = 1 together with multiplier bits [14:8] = the captured multiplier.
- R3: Every update is one read of the step's register followed by one write to the same address. The write data equals (read data AND NOT mask) OR (new field value AND mask), so all bits outside the step's field are preserved.
- R4: No write to register 0 changes both the reset bit and the enable bit relative to the value just read.
- R5: An accepted request with `req_on`=0 (power down) performs two updates to register 0, in this order: enable bit = 0, then reset bit = 0.
- R6: While `bus_req` is 1 and `bus_ack` is 0, the next cycle keeps `bus_req` at 1 with `bus_addr`, `bus_we` and `bus_wdata` unchanged. No new access begins before the current one is acknowledged.
- R7: `done` is high for exactly one cycle: the cycle after the last write of a sequence is acknowledged. `req_ready` returns to 1 in that same cycle.
- R8: `req_ready` is 0 from the cycle after acceptance until `done`. A request offered during that time is not taken and has no effect on the bus accesses.
- R9: Changes to `mult_nd` or `frac_word` after acceptance do not change the values written by the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_on | input | 1 | 1 = power up, 0 = power down |
| mult_nd | input | ND_W (7) | Integer multiplier field value |
| frac_word | input | FRAC_W (22) | Fractional multiplier word |
| bus_req | output | 1 | Bus access valid |
| bus_we | output | 1 | 1 = write, 0 = read |
| bus_addr | output | ADDR_W (8) | Register address |
| bus_wdata | output | DATA_W (32) | Write data |
| bus_rdata | input | DATA_W (32) | Read data, taken in the acknowledging cycle |
| bus_ack | input | 1 | Bus access ready / completed |
| done | output | 1 | One-cycle pulse at end of a sequence |

## Verification
The hardest case to reach is a competing request, or a change to the multiplier inputs, arriving while an access is stalled in the middle of a sequence. The bench's bus responder rotates its acknowledge delay between zero and two cycles on successive accesses, so reads and writes are held for different lengths. In that window the stimulus offers an opposite-direction request and zeroes both multiplier inputs. The bench register model then shows whether any stray access appeared, and whether a written field differed from the values captured at acceptance.

// File: rtl/fpll_seq_pkg.sv
package fpll_seq_pkg;
  localparam int STEP_W    = 2;
  localparam int ON_STEPS  = 4;
  localparam int OFF_STEPS = 2;

  typedef enum logic [1:0] {SQ_IDLE, SQ_ISSUE, SQ_WAIT} seq_state_e;
  typedef enum logic [1:0] {RM_IDLE, RM_READ, RM_WRITE} rmw_state_e;
endpackage

// File: rtl/fpll_step_rom.sv
module fpll_step_rom
  import fpll_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG0_ADDR = '0,
  parameter logic [ADDR_W-1:0] REG1_ADDR = 4,
  parameter int RSTN_BIT = 0,
  parameter int EN_BIT   = 1,
  parameter int ND_LSB   = 8,
  parameter int ND_W     = 7,
  parameter int FRAC_LSB = 0,
  parameter int FRAC_W   = 22
) (
  input  logic              op_on,
  input  logic [STEP_W-1:0] step,
  input  logic [ND_W-1:0]   nd,
  input  logic [FRAC_W-1:0] frac,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] val,
  output logic              last
);
  localparam logic [DATA_W-1:0] ONE    = DATA_W'(1);
  localparam logic [DATA_W-1:0] RSTN_M = ONE << RSTN_BIT;
  localparam logic [DATA_W-1:0] EN_M   = ONE << EN_BIT;
  localparam logic [DATA_W-1:0] ND_M   = ((ONE << ND_W) - ONE) << ND_LSB;
  localparam logic [DATA_W-1:0] FRAC_M = ((ONE << FRAC_W) - ONE) << FRAC_LSB;

  logic [DATA_W-1:0] nd_field, frac_field;
  assign nd_field   = DATA_W'(nd) << ND_LSB;
  assign frac_field = DATA_W'(frac) << FRAC_LSB;

  always_comb begin
    addr = REG0_ADDR;
    mask = '0;
    val  = '0;
    last = 1'b0;
    if (op_on) begin
      last = (step == STEP_W'(ON_STEPS - 1));
      case (step)
        2'd0: begin mask = RSTN_M; val = '0; end
        2'd1: begin mask = RSTN_M; val = RSTN_M; end
        2'd2: begin addr = REG1_ADDR; mask = FRAC_M; val = frac_field & FRAC_M; end
        default: begin mask = EN_M | ND_M; val = EN_M | (nd_field & ND_M); end
      endcase
    end else begin
      last = (step >= STEP_W'(OFF_STEPS - 1));
      case (step)
        2'd0:    begin mask = EN_M; val = '0; end
        default: begin mask = RSTN_M; val = '0; end
      endcase
    end
  end
endmodule

// File: rtl/fpll_rmw.sv
module fpll_rmw
  import fpll_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] val_i,
  output logic              fin,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack
);
  rmw_state_e        st;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] mask_q, val_q, wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= RM_IDLE;
      addr_q  <= '0;
      mask_q  <= '0;
      val_q   <= '0;
      wdata_q <= '0;
    end else begin
      case (st)
        RM_IDLE: if (start) begin
          addr_q <= addr_i;
          mask_q <= mask_i;
          val_q  <= val_i;
          st     <= RM_READ;
        end
        RM_READ: if (bus_ack) begin
          wdata_q <= (bus_rdata & ~mask_q) | (val_q & mask_q);
          st      <= RM_WRITE;
        end
        RM_WRITE: if (bus_ack) st <= RM_IDLE;
        default: st <= RM_IDLE;
      endcase
    end
  end

  assign bus_req   = (st != RM_IDLE);
  assign bus_we    = (st == RM_WRITE);
  assign bus_addr  = addr_q;
  assign bus_wdata = wdata_q;
  assign fin       = (st == RM_WRITE) && bus_ack;
endmodule

// File: rtl/fpll_seq.sv
module fpll_seq
  import fpll_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG0_ADDR = '0,
  parameter logic [ADDR_W-1:0] REG1_ADDR = 4,
  parameter int RSTN_BIT = 0,
  parameter int EN_BIT   = 1,
  parameter int ND_LSB   = 8,
  parameter int ND_W     = 7,
  parameter int FRAC_LSB = 0,
  parameter int FRAC_W   = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_on,
  input  logic [ND_W-1:0]   mult_nd,
  input  logic [FRAC_W-1:0] frac_word,
  output logic              bus_req,
  output logic              bus_we,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_ack,
  output logic              done
);
  seq_state_e        st;
  logic              op_q;
  logic [STEP_W-1:0] step_q;
  logic [ND_W-1:0]   nd_q;
  logic [FRAC_W-1:0] frac_q;
  logic              done_q;

  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_mask, s_val;
  logic              s_last, start, fin;

  fpll_step_rom #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG0_ADDR(REG0_ADDR), .REG1_ADDR(REG1_ADDR),
    .RSTN_BIT(RSTN_BIT), .EN_BIT(EN_BIT), .ND_LSB(ND_LSB), .ND_W(ND_W),
    .FRAC_LSB(FRAC_LSB), .FRAC_W(FRAC_W)
  ) u_rom (
    .op_on(op_q), .step(step_q), .nd(nd_q), .frac(frac_q),
    .addr(s_addr), .mask(s_mask), .val(s_val), .last(s_last)
  );

  fpll_rmw #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmw (
    .clk(clk), .rst_n(rst_n), .start(start),
    .addr_i(s_addr), .mask_i(s_mask), .val_i(s_val), .fin(fin),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack)
  );

  assign start     = (st == SQ_ISSUE);
  assign req_ready = (st == SQ_IDLE);
  assign done      = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= SQ_IDLE;
      op_q   <= 1'b0;
      step_q <= '0;
      nd_q   <= '0;
      frac_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        SQ_IDLE: if (req_valid) begin
          op_q   <= req_on;
          nd_q   <= mult_nd;
          frac_q <= frac_word;
          step_q <= '0;
          st     <= SQ_ISSUE;
        end
        SQ_ISSUE: st <= SQ_WAIT;
        SQ_WAIT: if (fin) begin
          if (s_last) begin
            st     <= SQ_IDLE;
            done_q <= 1'b1;
          end else begin
            step_q <= step_q + STEP_W'(1);
            st     <= SQ_ISSUE;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpll_seq_chk.sv
module fpll_seq_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] REG0_ADDR = '0,
  parameter int RSTN_BIT = 0,
  parameter int EN_BIT   = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              bus_req,
  input logic              bus_we,
  input logic              bus_ack,
  input logic              done,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata
);
  logic [DATA_W-1:0] rd_q;
  logic [ADDR_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q      <= '0;
      rd_addr_q <= '0;
    end else if (bus_req && bus_ack && !bus_we) begin
      rd_q      <= bus_rdata;
      rd_addr_q <= bus_addr;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req);

  p_same_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we) |-> (bus_addr == rd_addr_q));

  p_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_ack && bus_we && bus_addr == REG0_ADDR) |->
      ((rd_q[RSTN_BIT] == bus_wdata[RSTN_BIT]) || (rd_q[EN_BIT] == bus_wdata[EN_BIT])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=>
      (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(bus_req && bus_ack && bus_we));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
endmodule

bind fpll_seq fpll_seq_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG0_ADDR(REG0_ADDR),
  .RSTN_BIT(RSTN_BIT), .EN_BIT(EN_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack), .done(done),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
);

// File: tb/sim_fpll_seq.sv
`timescale 1ns/1ps
module sim_fpll_seq;
  localparam logic [7:0]  R0 = 8'h00;
  localparam logic [7:0]  R1 = 8'h04;
  localparam logic [31:0] RSTN_M = 32'h1;
  localparam logic [31:0] EN_M   = 32'h2;
  localparam logic [31:0] ND_M   = 32'h0000_7F00;
  localparam logic [31:0] FRAC_M = 32'h003F_FFFF;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_on = 0, bus_ack = 0;
  logic [6:0]  mult_nd = 0;
  logic [21:0] frac_word = 0;
  logic [31:0] bus_rdata = 0;
  logic req_ready, bus_req, bus_we, done;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata;

  always #4 clk = ~clk;

  fpll_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_on(req_on), .mult_nd(mult_nd), .frac_word(frac_word),
    .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack), .done(done)
  );

  int checks = 0, errors = 0;
  logic [31:0] reg0_m = 32'hC3C3_8004, reg1_m = 32'hFFC0_0000;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // reference model state
  logic [7:0]  qa[$];
  logic [31:0] qm[$], qv[$];
  bit e_busy = 0, e_done = 0, rd_seen = 0, pend = 0;
  logic [31:0] merged, rd_val, p_wdata;
  logic [7:0]  p_addr;
  logic        p_we;
  int wait_ctr = 0, acc_idx = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        e_busy = 0; e_done = 0; rd_seen = 0; pend = 0; bus_ack = 0;
      end else begin
        bit ack_n;
        chk(req_ready === !e_busy, "R8", "req_ready", 32'(req_ready), 32'(!e_busy));
        chk(done === e_done, "R7", "done", 32'(done), 32'(e_done));
        e_done = 0;
        if (pend)
          chk(bus_req && bus_addr == p_addr && bus_we == p_we && bus_wdata == p_wdata,
              "R6", "held access", bus_wdata, p_wdata);
        ack_n = 0;
        if (bus_req) begin
          if (qa.size() == 0) begin
            chk(0, "R8", "unexpected access addr", 32'(bus_addr), 32'hFFFF_FFFF);
          end else if (wait_ctr == acc_idx % 3) begin
            ack_n = 1; wait_ctr = 0; acc_idx++;
            if (!rd_seen) begin
              chk(!bus_we && bus_addr == qa[0], "R2", "read addr", 32'(bus_addr), 32'(qa[0]));
              rd_val = (qa[0] == R0) ? reg0_m : reg1_m;
              bus_rdata = rd_val;
              merged = (rd_val & ~qm[0]) | (qv[0] & qm[0]);
              rd_seen = 1;
            end else begin
              chk(bus_we && bus_addr == qa[0], "R3", "write addr", 32'(bus_addr), 32'(qa[0]));
              chk(bus_wdata == merged, "R3", "write data", bus_wdata, merged);
              if (qa[0] == R0) begin
                chk(!((bus_wdata[0] != rd_val[0]) && (bus_wdata[1] != rd_val[1])),
                    "R4", "reset and enable both changed", bus_wdata, rd_val);
                reg0_m = bus_wdata;
              end else reg1_m = bus_wdata;
              void'(qa.pop_front()); void'(qm.pop_front()); void'(qv.pop_front());
              rd_seen = 0;
              if (qa.size() == 0) begin e_done = 1; e_busy = 0; end
            end
          end else wait_ctr++;
        end
        pend = bus_req && !ack_n;
        p_addr = bus_addr; p_we = bus_we; p_wdata = bus_wdata;
        bus_ack = ack_n;
        if (req_valid && req_ready) begin
          e_busy = 1;
          if (req_on) begin
            qa.push_back(R0); qm.push_back(RSTN_M); qv.push_back(32'h0);
            qa.push_back(R0); qm.push_back(RSTN_M); qv.push_back(RSTN_M);
            qa.push_back(R1); qm.push_back(FRAC_M); qv.push_back(32'(frac_word));
            qa.push_back(R0); qm.push_back(EN_M | ND_M);
            qv.push_back(EN_M | (32'(mult_nd) << 8));
          end else begin
            qa.push_back(R0); qm.push_back(EN_M); qv.push_back(32'h0);
            qa.push_back(R0); qm.push_back(RSTN_M); qv.push_back(32'h0);
          end
        end
      end
    end
  end

  task automatic wait_done(input string tag);
    bit seen = 0;
    for (int i = 0; i < 300 && !seen; i++) begin
      @(negedge clk);
      if (done) seen = 1;
    end
    chk(seen, tag, "sequence completion", 32'(seen), 32'h1);
  endtask

  task automatic request(input bit on, input logic [6:0] nd, input logic [21:0] fr);
    @(posedge clk); #1;
    req_valid = 1; req_on = on; mult_nd = nd; frac_word = fr;
    @(posedge clk); #1;
    req_valid = 0;
  endtask

  logic [31:0] exp0;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(req_ready === 1 && bus_req === 0 && done === 0, "R1", "idle after reset",
        {29'b0, req_ready, bus_req, done}, 32'h4);

    // R2: power up
    exp0 = (reg0_m & ~(ND_M | EN_M | RSTN_M)) | EN_M | RSTN_M | (32'h1D << 8);
    request(1, 7'h1D, 22'h2AAAAA);
    wait_done("R2");
    chk(reg0_m == exp0, "R2", "reg0 after power up", reg0_m, exp0);
    chk(reg1_m == 32'hFFEA_AAAA, "R3", "reg1 upper bits kept", reg1_m, 32'hFFEA_AAAA);

    // R8/R9: competing request and input change mid-sequence
    exp0 = (reg0_m & ~ND_M) | (32'h7F << 8) | EN_M | RSTN_M;
    request(1, 7'h7F, 22'h3FFFFF);
    repeat (4) @(posedge clk);
    #1 req_valid = 1; req_on = 0; mult_nd = 0; frac_word = 0;
    @(posedge clk); #1 req_valid = 0;
    wait_done("R8");
    chk(reg0_m == exp0, "R9", "reg0 uses captured multiplier", reg0_m, exp0);
    chk(reg1_m[21:0] == 22'h3FFFFF, "R9", "captured fraction", reg1_m, 32'hFFFF_FFFF);
    repeat (20) @(negedge clk);
    chk(bus_req === 0, "R8", "no access from ignored request", 32'(bus_req), 32'h0);

    // R5: power down
    exp0 = reg0_m & ~(EN_M | RSTN_M);
    request(0, 7'h11, 22'h1);
    wait_done("R5");
    chk(reg0_m == exp0, "R5", "reg0 after power down", reg0_m, exp0);

    // R7: back-to-back requests, zero multipliers
    @(posedge clk); #1;
    req_valid = 1; req_on = 1; mult_nd = 0; frac_word = 0;
    wait_done("R7");
    @(posedge clk); #1 req_valid = 0;
    wait_done("R7");
    exp0 = (reg0_m & ~(ND_M | EN_M | RSTN_M)) | EN_M | RSTN_M;
    chk(reg0_m == exp0, "R2", "reg0 zero multiplier", reg0_m, exp0);
    chk(reg1_m == 32'hFFC0_0000, "R2", "reg1 zero fraction", reg1_m, 32'hFFC0_0000);
    repeat (10) @(negedge clk);
    chk(req_ready === 1 && bus_req === 0, "R1", "idle after sequences",
        {30'b0, req_ready, bus_req}, 32'h2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 100000);
    errors++; checks++;
    $display("FAIL R7 watchdog: actual hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule